// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block walks a PLL through a safe change of multiplier. Given a start pulse together with a 17-bit multiplier code and two loop-bandwidth fields (a proportional field and an integral field), it takes the PLL out of service, loads the new settings, powers it back up and then watches for lock. If lock appears, it turns the PLL clock output on and finishes cleanly. If lock does not appear, it finishes with an error and leaves the output off.

All PLL access goes through a simple register master port. A request lasts one cycle. Read data comes back on the cycle after the read request. The PLL registers sit at fixed byte offsets: status at 0x0, control at 0x4, multiplier word at 0x8 and divider word at 0xC. The wait between lock checks is a parameter counted in system clock cycles. With the default of 1000 cycles and a 100 MHz clock, this gives a 10 µs interval. The number of lock checks is also a parameter, with a default of four.

Top module: `pll_reprog_seq`

## Requirements
- R1: During reset and after it, with no start seen, busy, done, error and bus_req are all low.
- R2: A start pulse seen while idle raises busy. On the following cycle the block issues a read of control at offset 0x4. Multiplier code and bandwidth fields are captured on the same edge as start.
- R3: On the cycle after the control read data returns, control is written back with bit 0 (power-down) set and bits 4..1 (bypass, direct-in, direct-out, output enable) cleared. All other bits keep the value that was read.
- R4: On the next cycle the multiplier word is written to offset 0x8. The code goes in bits 16:0, the proportional field in bits 21:17 and the integral field in bits 27:22. The remaining bits are zero.
- R5: On the next cycle the divider word 0x00302062 is written to offset 0xC. This value selects divide-by-one for both the pre-divider and the post-divider.
- R6: On the next cycle control is written with the R3 value, except that bit 0 is cleared.
- R7: Before each status read at offset 0x0, the bus stays idle for exactly POLL_CYC cycles. Bit 0 of the returned status word means locked. The status word is evaluated one cycle after the read.
- R8: On the cycle after a status word that shows lock, control is written with the R6 value plus bit 4 set. On the next cycle done is high for one cycle and error stays low. After that, busy drops.
- R9: At most MAX_POLLS status reads are made. If none of them shows lock, done and error are high together for one cycle on the cycle after the last status word returns. No write that sets bit 4 is made.
- R10: A start pulse seen while busy, including during the done cycle, has no effect. The sequence in progress and its captured fields do not change, and no new sequence begins afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a reprogramming sequence |
| mul_code | input | 17 | Encoded multiplier code |
| bw_prop | input | 5 | Proportional bandwidth field |
| bw_int | input | 6 | Integral bandwidth field |
| bus_req | output | 1 | Register access request, one cycle |
| bus_we | output | 1 | High for a write, low for a read |
| bus_addr | output | 4 | Byte offset from the PLL base |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid the cycle after a read request |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | With done, lock was never seen |

## Verification
The hardest cases to reach from the ports are lock appearing only on the last permitted read, and lock never appearing at all. Both depend on the PLL side of the bus, not on this block's inputs. To reach them, the bench's PLL register stub can be set to report lock starting from a chosen status read: the first, the third, the last, or never. Start pulses carrying different fields are injected in the middle of a write burst and in the done cycle. This shows that the cycle-by-cycle bus trace stays the same as the undisturbed model predicts.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

   // control register bit positions (decoded by the PLL)
   localparam int CTL_PD   = 0;
   localparam int CTL_BYP  = 1;
   localparam int CTL_DIN  = 2;
   localparam int CTL_DOUT = 3;
   localparam int CTL_OEN  = 4;

   // status register lock bit
   localparam int STAT_LOCK = 0;

   // byte offsets from the PLL base
   localparam int OFS_STAT = 0;
   localparam int OFS_CTL  = 4;
   localparam int OFS_MUL  = 8;
   localparam int OFS_DIV  = 12;

   typedef enum logic [3:0] {
      SQ_IDLE,
      SQ_RD_CTL,
      SQ_CAP_CTL,
      SQ_WR_PD,
      SQ_WR_MUL,
      SQ_WR_DIV,
      SQ_WR_PU,
      SQ_WAIT,
      SQ_RD_STAT,
      SQ_EVAL,
      SQ_WR_OEN,
      SQ_FIN
   } seq_state_t;

endpackage

// File: rtl/pll_seq_word.sv
module pll_seq_word #(
   parameter int DATA_W   = 32,
   parameter int CODE_W   = 17,
   parameter int SELP_W   = 5,
   parameter int SELI_W   = 6,
   parameter int SELI_LSB = 22
) (
   input  logic [CODE_W-1:0] code,
   input  logic [SELP_W-1:0] selp,
   input  logic [SELI_W-1:0] seli,
   output logic [DATA_W-1:0] word
);
   localparam int SELP_LSB = CODE_W;

   initial begin
      assert (SELP_LSB + SELP_W <= SELI_LSB)
         else $error("proportional field overlaps integral field");
      assert (SELI_LSB + SELI_W <= DATA_W)
         else $error("integral field exceeds data width");
   end

   always_comb begin
      word                        = '0;
      word[CODE_W-1:0]            = code;
      word[SELP_LSB +: SELP_W]    = selp;
      word[SELI_LSB +: SELI_W]    = seli;
   end
endmodule

// File: rtl/pll_seq_ctl.sv
module pll_seq_ctl
   import pll_seq_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] ctl_raw,
   output logic [DATA_W-1:0] ctl_down,
   output logic [DATA_W-1:0] ctl_up,
   output logic [DATA_W-1:0] ctl_run
);
   localparam logic [DATA_W-1:0] MODE_MASK =
      (DATA_W'(1) << CTL_BYP) | (DATA_W'(1) << CTL_DIN) |
      (DATA_W'(1) << CTL_DOUT) | (DATA_W'(1) << CTL_OEN);
   localparam logic [DATA_W-1:0] PD_BIT  = DATA_W'(1) << CTL_PD;
   localparam logic [DATA_W-1:0] OEN_BIT = DATA_W'(1) << CTL_OEN;

   initial begin
      assert (DATA_W > CTL_OEN) else $error("control word too narrow");
   end

   always_comb begin
      ctl_down = (ctl_raw & ~MODE_MASK) | PD_BIT;
      ctl_up   = ctl_down & ~PD_BIT;
      ctl_run  = ctl_up | OEN_BIT;
   end
endmodule

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
   parameter int POLL_CYC = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);
   initial begin
      assert (POLL_CYC >= 1) else $error("poll interval must be at least one cycle");
   end

   generate
      if (POLL_CYC == 1) begin : g_single
         logic run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) run_q <= 1'b0;
            else        run_q <= load;
         end
         assign expired = run_q;
      end else begin : g_count
         localparam int CW = $clog2(POLL_CYC + 1);
         logic [CW-1:0] cnt_q;
         logic          run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               run_q <= 1'b0;
            end else if (load) begin
               cnt_q <= CW'(POLL_CYC - 1);
               run_q <= 1'b1;
            end else if (run_q) begin
               if (cnt_q == '0) run_q <= 1'b0;
               else             cnt_q <= cnt_q - 1'b1;
            end
         end
         assign expired = run_q && (cnt_q == '0);

         // R7
         cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            run_q |-> (cnt_q < CW'(POLL_CYC)));
      end
   endgenerate
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
   import pll_seq_pkg::*;
#(
   parameter int          DATA_W    = 32,
   parameter int          ADDR_W    = 4,
   parameter int          CODE_W    = 17,
   parameter int          SELP_W    = 5,
   parameter int          SELI_W    = 6,
   parameter int          SELI_LSB  = 22,
   parameter int          POLL_CYC  = 1000,
   parameter int          MAX_POLLS = 4,
   parameter logic [31:0] DIV_ONE   = 32'h0030_2062
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CODE_W-1:0] mul_code,
   input  logic [SELP_W-1:0] bw_prop,
   input  logic [SELI_W-1:0] bw_int,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              busy,
   output logic              done,
   output logic              error
);
   localparam int TW = $clog2(MAX_POLLS + 1);
   localparam logic [TW-1:0] LAST_TRY = TW'(MAX_POLLS - 1);

   initial begin
      assert (MAX_POLLS >= 1) else $error("need at least one status read");
      assert ((1 << ADDR_W) > OFS_DIV) else $error("address too narrow for register map");
      assert (DATA_W >= 32) else $error("data width below divider word");
   end

   seq_state_t        state_q, state_d;
   logic [DATA_W-1:0] ctl_q;
   logic [CODE_W-1:0] code_q;
   logic [SELP_W-1:0] selp_q;
   logic [SELI_W-1:0] seli_q;
   logic [TW-1:0]     tries_q;
   logic              fail_q;

   logic [DATA_W-1:0] mul_word, ctl_down, ctl_up, ctl_run;
   logic              tmr_load, tmr_expired;
   logic              locked;

   pll_seq_word #(
      .DATA_W(DATA_W), .CODE_W(CODE_W), .SELP_W(SELP_W),
      .SELI_W(SELI_W), .SELI_LSB(SELI_LSB)
   ) u_word (
      .code(code_q), .selp(selp_q), .seli(seli_q), .word(mul_word)
   );

   pll_seq_ctl #(.DATA_W(DATA_W)) u_ctl (
      .ctl_raw(ctl_q), .ctl_down(ctl_down), .ctl_up(ctl_up), .ctl_run(ctl_run)
   );

   pll_seq_timer #(.POLL_CYC(POLL_CYC)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .expired(tmr_expired)
   );

   assign locked = bus_rdata[STAT_LOCK];

   // next-state logic
   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      unique case (state_q)
         SQ_IDLE:    if (start) state_d = SQ_RD_CTL;
         SQ_RD_CTL:  state_d = SQ_CAP_CTL;
         SQ_CAP_CTL: state_d = SQ_WR_PD;
         SQ_WR_PD:   state_d = SQ_WR_MUL;
         SQ_WR_MUL:  state_d = SQ_WR_DIV;
         SQ_WR_DIV:  state_d = SQ_WR_PU;
         SQ_WR_PU: begin
            state_d  = SQ_WAIT;
            tmr_load = 1'b1;
         end
         SQ_WAIT:    if (tmr_expired) state_d = SQ_RD_STAT;
         SQ_RD_STAT: state_d = SQ_EVAL;
         SQ_EVAL: begin
            if (locked)                   state_d = SQ_WR_OEN;
            else if (tries_q == LAST_TRY) state_d = SQ_FIN;
            else begin
               state_d  = SQ_WAIT;
               tmr_load = 1'b1;
            end
         end
         SQ_WR_OEN:  state_d = SQ_FIN;
         SQ_FIN:     state_d = SQ_IDLE;
         default:    state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         ctl_q   <= '0;
         code_q  <= '0;
         selp_q  <= '0;
         seli_q  <= '0;
         tries_q <= '0;
         fail_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == SQ_IDLE && start) begin
            code_q  <= mul_code;
            selp_q  <= bw_prop;
            seli_q  <= bw_int;
            tries_q <= '0;
            fail_q  <= 1'b0;
         end
         if (state_q == SQ_CAP_CTL) ctl_q <= bus_rdata;
         if (state_q == SQ_EVAL && !locked) begin
            if (tries_q == LAST_TRY) fail_q <= 1'b1;
            else                     tries_q <= tries_q + 1'b1;
         end
      end
   end

   // register port drive
   always_comb begin
      bus_req   = 1'b0;
      bus_we    = 1'b0;
      bus_addr  = '0;
      bus_wdata = '0;
      unique case (state_q)
         SQ_RD_CTL: begin
            bus_req  = 1'b1;
            bus_addr = ADDR_W'(OFS_CTL);
         end
         SQ_WR_PD: begin
            bus_req = 1'b1; bus_we = 1'b1;
            bus_addr = ADDR_W'(OFS_CTL); bus_wdata = ctl_down;
         end
         SQ_WR_MUL: begin
            bus_req = 1'b1; bus_we = 1'b1;
            bus_addr = ADDR_W'(OFS_MUL); bus_wdata = mul_word;
         end
         SQ_WR_DIV: begin
            bus_req = 1'b1; bus_we = 1'b1;
            bus_addr = ADDR_W'(OFS_DIV); bus_wdata = DATA_W'(DIV_ONE);
         end
         SQ_WR_PU: begin
            bus_req = 1'b1; bus_we = 1'b1;
            bus_addr = ADDR_W'(OFS_CTL); bus_wdata = ctl_up;
         end
         SQ_RD_STAT: begin
            bus_req  = 1'b1;
            bus_addr = ADDR_W'(OFS_STAT);
         end
         SQ_WR_OEN: begin
            bus_req = 1'b1; bus_we = 1'b1;
            bus_addr = ADDR_W'(OFS_CTL); bus_wdata = ctl_run;
         end
         default: ;
      endcase
   end

   assign busy  = (state_q != SQ_IDLE);
   assign done  = (state_q == SQ_FIN);
   assign error = done && fail_q;

   // R3
   pd_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && bus_addr == ADDR_W'(OFS_CTL) && bus_wdata[CTL_PD])
         |-> (bus_wdata[CTL_OEN:CTL_BYP] == '0));

   // R8
   oen_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && bus_addr == ADDR_W'(OFS_CTL) && bus_wdata[CTL_OEN])
         |-> $past(bus_rdata[STAT_LOCK]));

   // R7
   stat_read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we && bus_addr == ADDR_W'(OFS_STAT)) |-> $past(!bus_req));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   error_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> done);

   // R10
   hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(code_q) && $stable(selp_q) && $stable(seli_q)));

endmodule

// File: tb/sim_pll_reprog_seq.sv
module sim_pll_reprog_seq;
   localparam int P   = 25;
   localparam int MXP = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [16:0] mul_code = '0;
   logic [4:0]  bw_prop = '0;
   logic [5:0]  bw_int = '0;
   logic        bus_req, bus_we;
   logic [3:0]  bus_addr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic        busy, done, error;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   pll_reprog_seq #(.POLL_CYC(P), .MAX_POLLS(MXP)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .mul_code(mul_code),
      .bw_prop(bw_prop), .bw_int(bw_int), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .busy(busy), .done(done), .error(error));

   // PLL register stub
   logic [31:0] regs [4];
   int          stat_reads;
   int          lock_at = 0;
   logic        cfg_load = 1'b0;
   logic [31:0] cfg_ctl = '0;

   always @(posedge clk) begin
      if (cfg_load) begin
         regs[1]    <= cfg_ctl;
         stat_reads <= 0;
      end else if (bus_req && bus_we && bus_addr[3:2] != 2'd0) begin
         regs[bus_addr[3:2]] <= bus_wdata;
      end else if (bus_req && !bus_we) begin
         if (bus_addr[3:2] == 2'd0) begin
            bus_rdata  <= {31'd0, (lock_at != 0 && stat_reads + 1 >= lock_at)};
            stat_reads <= stat_reads + 1;
         end else begin
            bus_rdata <= regs[bus_addr[3:2]];
         end
      end
   end

   typedef struct {
      bit          req;
      bit          we;
      logic [3:0]  addr;
      logic [31:0] wd;
      bit          bsy;
      bit          dn;
      bit          er;
      string       tag;
   } rec_t;

   rec_t expq[$];

   task automatic add(bit rq, bit w, logic [3:0] a, logic [31:0] d,
                      bit b, bit dn, bit er, string tg);
      rec_t r;
      r.req = rq; r.we = w; r.addr = a; r.wd = d;
      r.bsy = b; r.dn = dn; r.er = er; r.tag = tg;
      expq.push_back(r);
   endtask

   task automatic cmp(rec_t e);
      bit bad;
      checks++;
      bad = (bus_req !== e.req) || (busy !== e.bsy) || (done !== e.dn) || (error !== e.er);
      if (e.req)
         bad = bad || (bus_we !== e.we) || (bus_addr !== e.addr) || (bus_wdata !== e.wd);
      if (bad) begin
         errors++;
         $display("FAIL %s: got req=%0b we=%0b addr=%h wd=%h busy=%0b done=%0b err=%0b exp req=%0b we=%0b addr=%h wd=%h busy=%0b done=%0b err=%0b",
                  e.tag, bus_req, bus_we, bus_addr, bus_wdata, busy, done, error,
                  e.req, e.we, e.addr, e.wd, e.bsy, e.dn, e.er);
      end
   endtask

   // one full sequence against the behavioural model
   task automatic run_seq(logic [31:0] init_ctl, logic [16:0] c, logic [4:0] sp,
                          logic [5:0] si, int lk, bit disturb);
      logic [31:0] pd, pu, en, mw;
      logic [31:0] fin_ctl;
      int n;
      rec_t idle;
      pd = (init_ctl & ~32'h1E) | 32'h1;
      pu = pd & ~32'h1;
      en = pu | 32'h10;
      mw = {4'd0, si, sp, c};
      expq.delete();
      add(1, 0, 4'h4, '0, 1, 0, 0, "R2");
      add(0, 0, 4'h0, '0, 1, 0, 0, "R2");
      add(1, 1, 4'h4, pd, 1, 0, 0, "R3");
      add(1, 1, 4'h8, mw, 1, 0, 0, "R4");
      add(1, 1, 4'hC, 32'h0030_2062, 1, 0, 0, "R5");
      add(1, 1, 4'h4, pu, 1, 0, 0, "R6");
      fin_ctl = pu;
      for (int t = 1; t <= MXP; t++) begin
         for (int k = 0; k < P; k++) add(0, 0, 4'h0, '0, 1, 0, 0, "R7");
         add(1, 0, 4'h0, '0, 1, 0, 0, "R7");
         add(0, 0, 4'h0, '0, 1, 0, 0, "R7");
         if (lk != 0 && t >= lk) begin
            add(1, 1, 4'h4, en, 1, 0, 0, "R8");
            add(0, 0, 4'h0, '0, 1, 1, 0, "R8");
            fin_ctl = en;
            break;
         end
         if (t == MXP) add(0, 0, 4'h0, '0, 1, 1, 1, "R9");
      end
      // configure stub
      @(negedge clk);
      cfg_ctl = init_ctl; cfg_load = 1'b1; lock_at = lk;
      @(negedge clk);
      cfg_load = 1'b0;
      mul_code = c; bw_prop = sp; bw_int = si; start = 1'b1;
      n = expq.size();
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cmp(expq[i]);
         if (disturb && (i == 3 || i == n - 1)) begin
            // R10: start with different fields while busy
            start = 1'b1; mul_code = ~c; bw_prop = ~sp; bw_int = ~si;
         end else begin
            start = 1'b0;
         end
      end
      @(negedge clk);
      start = 1'b0;
      idle.req = 0; idle.we = 0; idle.addr = 0; idle.wd = 0;
      idle.bsy = 0; idle.dn = 0; idle.er = 0; idle.tag = "R10";
      cmp(idle);
      repeat (2) @(negedge clk);
      cmp(idle);
      checks++;
      if (regs[1] !== fin_ctl) begin
         errors++;
         $display("FAIL %s: control reg got %h exp %h", (lk == 0) ? "R9" : "R8",
                  regs[1], fin_ctl);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      checks++;
      if (busy !== 0 || done !== 0 || error !== 0 || bus_req !== 0) begin
         errors++;
         $display("FAIL R1: got busy=%0b done=%0b err=%0b req=%0b exp 0 0 0 0",
                  busy, done, error, bus_req);
      end
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      checks++;
      if (busy !== 0 || done !== 0 || bus_req !== 0) begin
         errors++;
         $display("FAIL R1: got busy=%0b done=%0b req=%0b exp 0 0 0", busy, done, bus_req);
      end
      run_seq(32'hA5A5_5A1E, 17'h1_2345, 5'd31, 6'd8,  1, 1'b0);
      run_seq(32'h0000_0000, 17'h0_4000, 5'd3,  6'd44, 3, 1'b0);
      run_seq(32'hFFFF_FFFF, 17'h1_FFFF, 5'd17, 6'd63, 0, 1'b0);
      run_seq(32'h1234_5670, 17'h1_8003, 5'd1,  6'd4,  MXP, 1'b1);
      run_seq(32'hDEAD_BEEF, 17'h0_0ACE, 5'd9,  6'd21, 0, 1'b1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule